// File: doc/BRIEF.md
# Snoop Inquire Initiator

This block sits on the system side of a processor bus. It runs one external cache inquire (snoop) against the processor for each request it accepts. A request carries a cache-line address, an invalidate flag and the way the bus is to be taken from the processor. There are three ways: address hold, back-off, or a hold request answered by hold-acknowledge. Once the bus is taken, the block pulses the external address strobe. The strobe carries the line address and the invalidate flag. Two cycles later the block samples the processor's hit, hit-modified and address-parity-error responses.

A parity error makes the block discard the hit responses and strobe the same line again, up to a configurable number of times. A modified hit makes the block release the bus so that the processor can write the line back. The block then counts four ready pulses before it reports completion. A single-cycle done pulse carries the result class, the number of retries spent and a failure flag.

Top module: `snoop_inquirer`

## Requirements
- R1: `req_ready` is high exactly when the block is idle; a request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and address, invalidate flag and method are latched there; while busy, request inputs have no effect on the strobed address or on the bus signals, and no inquire starts after completion without a new request.
- R2: Method 0 raises `snp_ahold_o` and method 1 raises `snp_boff_o` on the accept edge; the address strobe `snp_eads_o` rises exactly two cycles after that signal rises.
- R3: Methods 2 and 3 raise `snp_hold_o` on the accept edge; the strobe is never raised while `snp_hlda_i` has not been seen high, and rises one cycle after the edge on which `snp_hlda_i` is first sampled high.
- R4: The strobe lasts one cycle; `snp_addr_o` carries the latched line address (address bits 31..5) and `snp_inv_o` the latched invalidate flag during the strobe, and both are zero otherwise.
- R5: Hit inputs are sampled on the second edge after the strobe edge; if no parity error is reported there and `snp_hitm_i` is low, `done_o` pulses on that edge with `res_kind` 0 (miss, hit low) or 1 (clean hit), and the bus signal is dropped on that same edge.
- R6: If `snp_hitm_i` is high at the sampling edge (with or without hit), the bus signal is dropped on that edge, `done_o` stays low, and it pulses on the edge that samples the fourth `snp_brdy_i` pulse, with `res_kind` 2 (modified).
- R7: No strobe is issued between a modified-hit response and the fourth ready pulse.
- R8: If `snp_apchk_i` is high at the sampling edge and fewer than MAX_RETRY retries have been used, the hit inputs are ignored, no completion is reported, the bus stays held, and the strobe is repeated two cycles later; `res_retries` at completion equals the number of repeats.
- R9: A parity error at the sampling edge after MAX_RETRY retries ends the inquire: `done_o` pulses with `res_fail` high, `res_kind` 0, `res_retries` equal to MAX_RETRY, and the bus signal dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Inquire request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | LINE_AW | Cache-line address (bits 31..5) |
| req_inv | input | 1 | Invalidate the line on a hit |
| req_method | input | 2 | 0 address hold, 1 back-off, 2/3 hold request |
| snp_ahold_o | output | 1 | Address hold to processor |
| snp_boff_o | output | 1 | Back-off to processor |
| snp_hold_o | output | 1 | Bus hold request to processor |
| snp_hlda_i | input | 1 | Hold acknowledge from processor |
| snp_eads_o | output | 1 | External address strobe |
| snp_addr_o | output | LINE_AW | Line address, valid during strobe |
| snp_inv_o | output | 1 | Invalidate flag, valid during strobe |
| snp_hit_i | input | 1 | Processor reports line present |
| snp_hitm_i | input | 1 | Processor reports line modified |
| snp_apchk_i | input | 1 | Processor reports address parity error |
| snp_brdy_i | input | 1 | Writeback transfer ready |
| done_o | output | 1 | One-cycle completion pulse |
| res_kind | output | 2 | 0 miss, 1 clean hit, 2 modified hit |
| res_retries | output | RETRY_W | Retries spent, valid with done_o |
| res_fail | output | 1 | Retry budget exhausted, valid with done_o |

## Verification
Most faults in the sequencer show up within one to three cycles at the processor-side pins. A wrong lag count moves the strobe off its fixed slot after the acquisition signal or the acknowledge. A stuck state leaves the acquisition signal high after `done_o`, or issues a second strobe during a writeback. Faults in the retry and beat bookkeeping appear only at completion, as a wrong `res_retries`, `res_kind` or `res_fail`, or as `done_o` one ready pulse early or late. The bench therefore checks every pin on every cycle of the strobe window and checks the result fields on the done cycle.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLDW,
        ST_PRE,
        ST_RESP,
        ST_WB
    } snp_state_e;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_CLEAN = 2'd1,
        RES_MOD   = 2'd2
    } snp_res_e;

    localparam int METH_W   = 2;
    localparam int N_GRAB   = 3;

endpackage

// File: rtl/snp_grab_dec.sv
module snp_grab_dec
    import snp_pkg::*;
#(
    parameter int N_WAYS = N_GRAB
) (
    input  logic              grab,
    input  logic [METH_W-1:0] meth,
    output logic [N_WAYS-1:0] sel
);
    localparam int LAST = N_WAYS - 1;

    for (genvar i = 0; i < N_WAYS; i++) begin : g_way
        if (i == LAST) begin : g_tail
            assign sel[i] = grab && (int'(meth) >= LAST);
        end else begin : g_exact
            assign sel[i] = grab && (int'(meth) == i);
        end
    end

endmodule

// File: rtl/snp_beat_ctr.sv
module snp_beat_ctr #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic beat,
    output logic last
);
    localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign last = beat && (cnt_q == CW'(BEATS - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr || last) begin
            cnt_d = '0;
        end else if (beat) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R6
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt_q == '0));

endmodule

// File: rtl/snoop_inquirer.sv
module snoop_inquirer
    import snp_pkg::*;
#(
    parameter int LINE_AW   = 27,
    parameter int MAX_RETRY = 3,
    parameter int GRAB_LAG  = 2,
    parameter int RESP_LAG  = 2,
    parameter int RETRY_LAG = 2,
    parameter int WB_BEATS  = 4,
    localparam int RETRY_W  = $clog2(MAX_RETRY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [LINE_AW-1:0] req_addr,
    input  logic               req_inv,
    input  logic [1:0]         req_method,
    output logic               snp_ahold_o,
    output logic               snp_boff_o,
    output logic               snp_hold_o,
    input  logic               snp_hlda_i,
    output logic               snp_eads_o,
    output logic [LINE_AW-1:0] snp_addr_o,
    output logic               snp_inv_o,
    input  logic               snp_hit_i,
    input  logic               snp_hitm_i,
    input  logic               snp_apchk_i,
    input  logic               snp_brdy_i,
    output logic               done_o,
    output logic [1:0]         res_kind,
    output logic [RETRY_W-1:0] res_retries,
    output logic               res_fail
);
    localparam int LAG_A   = (GRAB_LAG > RESP_LAG) ? GRAB_LAG : RESP_LAG;
    localparam int MAX_LAG = (LAG_A > RETRY_LAG) ? LAG_A : RETRY_LAG;
    localparam int TMR_W   = $clog2(MAX_LAG + 1);

    typedef struct packed {
        snp_state_e         state;
        logic [TMR_W-1:0]   tmr;
        logic               grab;
        logic [METH_W-1:0]  meth;
        logic [LINE_AW-1:0] addr;
        logic               inv;
        logic               eads;
        logic [RETRY_W-1:0] retries;
        logic               done;
        logic [1:0]         kind;
        logic               fail;
    } regs_t;

    regs_t q, d;
    logic  beat_last;
    logic  beat_clr;
    logic  beat_in;
    logic [N_GRAB-1:0] grab_sel;

    snp_grab_dec #(.N_WAYS(N_GRAB)) u_grab (
        .grab (q.grab),
        .meth (q.meth),
        .sel  (grab_sel)
    );

    assign beat_clr = (q.state != ST_WB);
    assign beat_in  = snp_brdy_i && (q.state == ST_WB);

    snp_beat_ctr #(.BEATS(WB_BEATS)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (beat_clr),
        .beat  (beat_in),
        .last  (beat_last)
    );

    always_comb begin
        d      = q;
        d.eads = 1'b0;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr    = req_addr;
                    d.inv     = req_inv;
                    d.meth    = req_method;
                    d.retries = '0;
                    d.grab    = 1'b1;
                    if (req_method[1]) begin
                        d.state = ST_HOLDW;
                    end else begin
                        d.state = ST_PRE;
                        d.tmr   = TMR_W'(GRAB_LAG - 1);
                    end
                end
            end
            ST_HOLDW: begin
                if (snp_hlda_i) begin
                    d.state = ST_PRE;
                    d.tmr   = '0;
                end
            end
            ST_PRE: begin
                if (q.tmr == '0) begin
                    d.eads  = 1'b1;
                    d.state = ST_RESP;
                    d.tmr   = TMR_W'(RESP_LAG - 1);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_RESP: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else if (snp_apchk_i) begin
                    if (q.retries == RETRY_W'(MAX_RETRY)) begin
                        d.done  = 1'b1;
                        d.fail  = 1'b1;
                        d.kind  = RES_MISS;
                        d.grab  = 1'b0;
                        d.state = ST_IDLE;
                    end else begin
                        d.retries = q.retries + 1'b1;
                        d.state   = ST_PRE;
                        d.tmr     = TMR_W'(RETRY_LAG - 1);
                    end
                end else if (snp_hitm_i) begin
                    d.grab  = 1'b0;
                    d.kind  = RES_MOD;
                    d.fail  = 1'b0;
                    d.state = ST_WB;
                end else begin
                    d.done  = 1'b1;
                    d.grab  = 1'b0;
                    d.fail  = 1'b0;
                    d.kind  = snp_hit_i ? RES_CLEAN : RES_MISS;
                    d.state = ST_IDLE;
                end
            end
            ST_WB: begin
                if (beat_last) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.state == ST_IDLE);
    assign snp_ahold_o = grab_sel[0];
    assign snp_boff_o  = grab_sel[1];
    assign snp_hold_o  = grab_sel[2];
    assign snp_eads_o  = q.eads;
    assign snp_addr_o  = q.eads ? q.addr : '0;
    assign snp_inv_o   = q.eads && q.inv;
    assign done_o      = q.done;
    assign res_kind    = q.kind;
    assign res_retries = q.retries;
    assign res_fail    = q.fail;

    // R1
    idle_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(snp_ahold_o || snp_boff_o || snp_hold_o));

    // R2
    strobe_has_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_eads_o |-> (snp_ahold_o || snp_boff_o || snp_hold_o));

    // R3
    hold_strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_eads_o && snp_hold_o) |-> $past(snp_hlda_i));

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_eads_o |=> !snp_eads_o);

    // R5
    done_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(snp_ahold_o || snp_boff_o || snp_hold_o));

    // R7
    wb_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WB) |-> !snp_eads_o);

    // R8
    retry_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RESP && q.tmr == '0 && snp_apchk_i
         && q.retries != RETRY_W'(MAX_RETRY)) |=> !done_o);

endmodule

// File: tb/snoop_inquirer_bench.sv
module snoop_inquirer_bench;
    localparam int AW    = 27;
    localparam int MAXR  = 3;
    localparam int RW    = $clog2(MAXR + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic req_inv = 1'b0;
    logic [1:0] req_method = '0;
    logic ahold, boff, hold;
    logic hlda = 1'b0;
    logic eads;
    logic [AW-1:0] saddr;
    logic sinv;
    logic hit = 1'b0, hitm = 1'b0, apchk = 1'b0, brdy = 1'b0;
    logic done;
    logic [1:0] kind;
    logic [RW-1:0] retries;
    logic fail;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    snoop_inquirer #(.LINE_AW(AW), .MAX_RETRY(MAXR)) u_snoop_inquirer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_inv(req_inv), .req_method(req_method),
        .snp_ahold_o(ahold), .snp_boff_o(boff), .snp_hold_o(hold),
        .snp_hlda_i(hlda), .snp_eads_o(eads), .snp_addr_o(saddr),
        .snp_inv_o(sinv), .snp_hit_i(hit), .snp_hitm_i(hitm),
        .snp_apchk_i(apchk), .snp_brdy_i(brdy),
        .done_o(done), .res_kind(kind), .res_retries(retries), .res_fail(fail)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_kind(input int resp, input int napchk);
        if (napchk > MAXR) return 0;
        if (resp >= 2) return 2;
        return resp;
    endfunction

    function automatic int exp_retries(input int napchk);
        return (napchk > MAXR) ? MAXR : napchk;
    endfunction

    function automatic int grab_vec(input int meth);
        return (meth == 0) ? 1 : (meth == 1) ? 2 : 4;
    endfunction

    // resp: 0 none, 1 hit, 2 hitm, 3 hit+hitm
    task automatic do_inq(input int meth, input logic [AW-1:0] a, input bit inv,
                          input int napchk, input int resp, input int hdly);
        int r;
        bit go;
        string stag;
        stag = (meth < 2) ? "R2" : "R3";
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        req_valid  = 1'b1;
        req_addr   = a;
        req_inv    = inv;
        req_method = 2'(meth);
        @(negedge clk);
        req_addr   = ~a;
        req_inv    = ~inv;
        req_method = (meth == 0) ? 2'd1 : 2'd0;
        chk(req_ready == 1'b0, "R1", int'(req_ready), 0);
        chk(int'({hold, boff, ahold}) == grab_vec(meth), stag,
            int'({hold, boff, ahold}), grab_vec(meth));
        if (meth >= 2) begin
            repeat (hdly) begin
                chk(eads == 1'b0, "R3", int'(eads), 0);
                @(negedge clk);
            end
            hlda = 1'b1;
            @(negedge clk);
            chk(eads == 1'b0, "R3", int'(eads), 0);
            @(negedge clk);
        end else begin
            chk(eads == 1'b0, "R2", int'(eads), 0);
            @(negedge clk);
            chk(eads == 1'b0, "R2", int'(eads), 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        r  = 0;
        go = 1'b1;
        while (go) begin
            chk(eads == 1'b1, (r == 0) ? stag : "R8", int'(eads), 1);
            chk(saddr == a, "R4", int'(saddr), int'(a));
            chk(sinv == inv, "R4", int'(sinv), int'(inv));
            @(negedge clk);
            chk(eads == 1'b0 && saddr == '0 && !sinv, "R4", int'(eads), 0);
            if (r < napchk) begin
                apchk = 1'b1;
                hit   = 1'($urandom_range(0, 1));
                hitm  = 1'($urandom_range(0, 1));
            end else begin
                hit  = resp[0];
                hitm = resp[1];
            end
            @(negedge clk);
            apchk = 1'b0; hit = 1'b0; hitm = 1'b0;
            if (r < napchk && r < MAXR) begin
                chk(done == 1'b0 && eads == 1'b0, "R8", int'(done), 0);
                chk(int'({hold, boff, ahold}) == grab_vec(meth), "R8",
                    int'({hold, boff, ahold}), grab_vec(meth));
                @(negedge clk);
                chk(eads == 1'b0, "R8", int'(eads), 0);
                @(negedge clk);
                r++;
            end else begin
                go = 1'b0;
            end
        end
        chk({hold, boff, ahold} == 3'b000, "R5", int'({hold, boff, ahold}), 0);
        hlda = 1'b0;
        if (napchk > MAXR) begin
            chk(done == 1'b1 && fail == 1'b1, "R9", int'({done, fail}), 3);
            chk(int'(kind) == 0, "R9", int'(kind), 0);
            chk(int'(retries) == MAXR, "R9", int'(retries), MAXR);
        end else if (resp >= 2) begin
            chk(done == 1'b0, "R6", int'(done), 0);
            for (int b = 0; b < 4; b++) begin
                repeat ($urandom_range(0, 2)) begin
                    chk(eads == 1'b0 && done == 1'b0, "R7", int'(eads), 0);
                    @(negedge clk);
                end
                brdy = 1'b1;
                @(negedge clk);
                brdy = 1'b0;
                chk(eads == 1'b0, "R7", int'(eads), 0);
                chk(done == (b == 3), "R6", int'(done), int'(b == 3));
            end
            chk(int'(kind) == 2 && fail == 1'b0, "R6", int'(kind), 2);
            chk(int'(retries) == exp_retries(napchk), "R8", int'(retries),
                exp_retries(napchk));
        end else begin
            chk(done == 1'b1, "R5", int'(done), 1);
            chk(int'(kind) == exp_kind(resp, napchk) && fail == 1'b0, "R5",
                int'(kind), exp_kind(resp, napchk));
            chk(int'(retries) == exp_retries(napchk), "R8", int'(retries),
                exp_retries(napchk));
        end
        repeat (3) begin
            @(negedge clk);
            chk(done == 1'b0 && eads == 1'b0 && {hold, boff, ahold} == 3'b000,
                "R1", int'({done, eads, hold, boff, ahold}), 0);
        end
    endtask

    initial begin
        int lim;
        lim = 0;
        while (lim < 100000) begin
            @(posedge clk);
            lim++;
        end
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", lim, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_ready && !eads && !done && {hold, boff, ahold} == 3'b000, "R1",
            int'({req_ready, eads, done}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && eads == 1'b0, "R1", int'(req_ready), 1);

        // directed corners
        do_inq(0, 27'h1234567, 1'b0, 0, 0, 0);
        do_inq(1, 27'h7ffffff, 1'b1, 0, 1, 0);
        do_inq(2, 27'h0000001, 1'b1, 0, 2, 0);
        do_inq(3, 27'h2aaaaaa, 1'b0, 0, 3, 5);
        do_inq(0, 27'h5555555, 1'b1, 0, 2, 0);
        do_inq(1, 27'h0abcdef, 1'b0, 1, 1, 0);
        do_inq(2, 27'h3333333, 1'b1, MAXR, 2, 2);
        do_inq(0, 27'h4444444, 1'b0, MAXR + 1, 3, 0);
        do_inq(2, 27'h6666666, 1'b1, MAXR + 1, 0, 1);

        // constrained random
        for (int i = 0; i < 60; i++) begin
            do_inq($urandom_range(0, 3), AW'($urandom), 1'($urandom_range(0, 1)),
                   ($urandom_range(0, 3) == 0) ? $urandom_range(1, MAXR + 1) : 0,
                   $urandom_range(0, 3), $urandom_range(0, 4));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule